// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a per-processor counter/timer with two personalities, chosen by an external mode input. In counter mode it counts up in steps of 0x200 on every tick and compares the count against a software-set limit. When the count reaches the limit, it wraps to zero, sets a reached flag and raises an interrupt. In user mode the same storage becomes a 63-bit free-running counter. That counter never interrupts, software starts and stops it with a run bit, and it is loaded and read as an upper and a lower 32-bit word.

Software reaches the block through a 32-bit register port that covers four word slots, which make up a 16-byte window. Every request is accepted in the cycle it is presented, so there is no back-pressure. Each read produces exactly one response one cycle later, and nothing can stall it. The tick input is a single-cycle pulse from a shared timebase, nominally every 500 ns. The mode input comes from a shared mode register that lies outside this block. The block registers that input and applies the side effects of a mode change on the clock edge after it first sees the input differ from its registered copy.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the block is in counter mode with count 0, limit 0, reached flag clear, interrupt low and run bit 1.
- R2: In counter mode every tick advances the count by 0x200 whatever the run bit holds. With a nonzero limit, the tick on which count+0x200 is at least the limit sets the count to 0, sets the reached flag and raises the interrupt.
- R3: In counter mode with limit 0 the count runs freely and never sets the reached flag or the interrupt.
- R4: In counter mode, a read of word 0 returns the limit in bits 30:9 and clears both the reached flag and the interrupt. A write to word 0 loads the limit from wdata[30:9], clears the count and lowers the interrupt. A read of word 1 returns the reached flag in bit 31 and the count in bits 30:9. A write to word 1 changes nothing.
- R5: In either mode, a write to word 2 loads the limit from wdata[30:9] and leaves the count and the interrupt untouched. A read of word 2 returns zero.
- R6: In user mode, a read of word 0 returns the reached flag in bit 31 and count bits 62:32 in bits 30:0. A read of word 1 returns count bits 31:0, whose bits 8:0 are always zero.
- R7: In user mode, a write to word 0 loads count bits 62:32 from wdata[30:0]. A write to word 1 loads count bits 31:9 from wdata[31:9]. Either write clears the reached flag, and counting continues from the loaded value.
- R8: In user mode the count advances 0x200 per tick only while the run bit is 1. A tick taken at 0x7FFFFFFFFFFFFE00 wraps the count to 0 and sets the reached flag. The interrupt stays low for as long as the block is in user mode.
- R9: A write to word 3 stores wdata[0] as the run bit. A read of word 3 returns the run bit in bit 0 and zeros elsewhere.
- R10: On the edge where the block first sees the mode input go from counter to user, the interrupt is lowered and the limit becomes 0x7FFFFE00. The reached flag and the count keep their values.
- R11: On the edge where the block first sees the mode input go from user to counter, the run bit is set to 1, count bits 62:31 are cleared, and from then on the count advances on every tick.
- R12: A tick in the same cycle as an accepted write is discarded. A read produces rsp_valid on the next cycle, with data taken from the state before the read's edge. If a clearing read of word 0 and a limit match fall in the same cycle, the reached flag and the interrupt both end up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse, one count step |
| mode_user_i | input | 1 | 1 selects user mode, 0 selects counter mode |
| req_valid_i | input | 1 | Register request present, always accepted |
| req_write_i | input | 1 | 1 write, 0 read |
| req_word_i | input | 2 | Word slot within the 16-byte window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the read |
| rsp_data_o | output | 32 | Read response data |
| irq_o | output | 1 | Interrupt, level |

## Verification
The hardest case to reach is the user-mode wrap at the 63-bit maximum, because counting there from reset would take far longer than any run. The stimulus first loads both words to one step below the maximum and then issues two ticks. The overlaps between a mode change, a read and a tick are also rare at the ports. Directed sequences place a clearing read on the exact tick of a limit match, a write on the same cycle as a tick, and a mode change into user mode while the interrupt is high. A long randomized stretch then mixes all of these against the cycle model.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [1:0] {
    SLOT_LIMIT   = 2'd0,
    SLOT_COUNT   = 2'd1,
    SLOT_LIMKEEP = 2'd2,
    SLOT_RUN     = 2'd3
  } slot_e;

  typedef struct packed {
    logic rd_limit_ctr;   // counter-mode read of word 0 (clearing read)
    logic wr_limit_rst;   // counter-mode write of word 0
    logic wr_limit_keep;  // write of word 2, any mode
    logic wr_run;         // write of word 3
    logic ld_hi;          // user-mode upper word load
    logic ld_lo;          // user-mode lower word load
  } acc_t;

endpackage

// File: rtl/dmt_mode_track.sv
module dmt_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic user_o,
  output logic enter_user_o,
  output logic enter_ctr_o
);

  logic user_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) user_q <= 1'b0;
    else        user_q <= mode_i;
  end

  assign user_o       = user_q;
  assign enter_user_o = mode_i & ~user_q;
  assign enter_ctr_o  = ~mode_i & user_q;

endmodule

// File: rtl/dmt_decode.sv
module dmt_decode
  import dmt_pkg::*;
(
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic [1:0] req_word_i,
  input  logic       user_i,
  input  logic       tick_i,
  output acc_t       acc_o,
  output slot_e      slot_o,
  output logic       rd_o,
  output logic       tick_o
);

  logic wr;

  always_comb begin
    slot_o = slot_e'(req_word_i);
    wr     = req_valid_i & req_write_i;
    rd_o   = req_valid_i & ~req_write_i;
    // an accepted write owns the cycle: the timebase step is dropped
    tick_o = tick_i & ~wr;

    acc_o               = '0;
    acc_o.rd_limit_ctr  = rd_o & (slot_o == SLOT_LIMIT) & ~user_i;
    acc_o.wr_limit_rst  = wr & (slot_o == SLOT_LIMIT) & ~user_i;
    acc_o.ld_hi         = wr & (slot_o == SLOT_LIMIT) & user_i;
    acc_o.ld_lo         = wr & (slot_o == SLOT_COUNT) & user_i;
    acc_o.wr_limit_keep = wr & (slot_o == SLOT_LIMKEEP);
    acc_o.wr_run        = wr & (slot_o == SLOT_RUN);
  end

endmodule

// File: rtl/dmt_count_core.sv
module dmt_count_core #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 9,
  parameter int P_W    = 54,
  parameter int L_W    = 22,
  parameter int HI     = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              user_i,
  input  logic              run_i,
  input  logic [L_W-1:0]    lim_i,
  input  logic              clr_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              trunc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [P_W-1:0]    cnt_o,
  output logic              match_o,
  output logic              wrap_o
);

  localparam int HW = P_W - HI;

  // count held in units of one step; bits below SUB_W are implicit zeros
  logic [P_W-1:0] cnt_q, cnt_n;
  logic [L_W:0]   step;

  always_comb begin
    cnt_n   = cnt_q;
    match_o = 1'b0;
    wrap_o  = 1'b0;
    step    = {1'b0, cnt_q[L_W-1:0]} + (L_W+1)'(1);

    if (tick_i) begin
      if (user_i) begin
        if (run_i) begin
          if (&cnt_q) begin
            cnt_n  = '0;
            wrap_o = 1'b1;
          end else begin
            cnt_n = cnt_q + P_W'(1);
          end
        end
      end else if ((lim_i != '0) && (step >= {1'b0, lim_i})) begin
        cnt_n   = '0;
        match_o = 1'b1;
      end else begin
        cnt_n = P_W'(step[L_W-1:0]);
      end
    end

    if (clr_i)   cnt_n = '0;
    if (ld_hi_i) cnt_n[P_W-1:HI] = wdata_i[HW-1:0];
    if (ld_lo_i) cnt_n[HI-1:0]   = wdata_i[DATA_W-1:SUB_W];
    if (trunc_i) cnt_n[P_W-1:L_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (user_i && !run_i && !ld_hi_i && !ld_lo_i && !trunc_i) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 9,
  parameter int P_W    = 54,
  parameter int L_W    = 22,
  parameter int HI     = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc_i,
  input  logic              rd_i,
  input  slot_e             slot_i,
  input  logic              user_i,
  input  logic              enter_user_i,
  input  logic              enter_ctr_i,
  input  logic              match_i,
  input  logic              wrap_i,
  input  logic [P_W-1:0]    cnt_i,
  input  logic [L_W-1:0]    lim_wd_i,
  input  logic              run_wd_i,
  output logic [L_W-1:0]    lim_o,
  output logic              run_o,
  output logic              irq_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  localparam int PAD_L = DATA_W - L_W - SUB_W - 1;

  logic [L_W-1:0]    lim_q, lim_n;
  logic              run_q, run_n;
  logic              irq_q, irq_n;
  logic              rch_q, rch_n;
  logic              rv_q;
  logic [DATA_W-1:0] rd_q, rd_n;

  // read mux sees the state before this edge
  always_comb begin
    rd_n = '0;
    unique case (slot_i)
      SLOT_LIMIT:
        if (user_i) rd_n = {rch_q, cnt_i[P_W-1:HI]};
        else        rd_n = {1'b0, {PAD_L{1'b0}}, lim_q, {SUB_W{1'b0}}};
      SLOT_COUNT:
        if (user_i) rd_n = {cnt_i[HI-1:0], {SUB_W{1'b0}}};
        else        rd_n = {rch_q, {PAD_L{1'b0}}, cnt_i[L_W-1:0], {SUB_W{1'b0}}};
      SLOT_LIMKEEP: rd_n = '0;
      SLOT_RUN:     rd_n = {{(DATA_W-1){1'b0}}, run_q};
      default:      rd_n = '0;
    endcase
  end

  // state update order: clearing read, count event, write, mode change
  always_comb begin
    lim_n = lim_q;
    run_n = run_q;
    irq_n = irq_q;
    rch_n = rch_q;

    if (acc_i.rd_limit_ctr) begin
      rch_n = 1'b0;
      irq_n = 1'b0;
    end
    if (match_i) begin
      rch_n = 1'b1;
      irq_n = 1'b1;
    end
    if (wrap_i) rch_n = 1'b1;

    if (acc_i.wr_limit_rst) begin
      lim_n = lim_wd_i;
      irq_n = 1'b0;
    end
    if (acc_i.wr_limit_keep) lim_n = lim_wd_i;
    if (acc_i.ld_hi || acc_i.ld_lo) rch_n = 1'b0;
    if (acc_i.wr_run) run_n = run_wd_i;

    if (enter_user_i) begin
      irq_n = 1'b0;
      lim_n = '1;
    end
    if (enter_ctr_i) run_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      run_q <= 1'b1;
      irq_q <= 1'b0;
      rch_q <= 1'b0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      lim_q <= lim_n;
      run_q <= run_n;
      irq_q <= irq_n;
      rch_q <= rch_n;
      rv_q  <= rd_i;
      if (rd_i) rd_q <= rd_n;
    end
  end

  assign lim_o       = lim_q;
  assign run_o       = run_q;
  assign irq_o       = irq_q;
  assign rsp_valid_o = rv_q;
  assign rsp_data_o  = rd_q;

  AST_USER_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    user_i |-> !irq_q); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(!user_i && (lim_q != '0))); // R2
  AST_ENTER_USER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    enter_user_i |=> ((&lim_q) && !irq_q)); // R10
  AST_CTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ctr_i |=> run_q); // R11

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 9,
  parameter int CNT_W  = 63,
  parameter int LIM_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              mode_user_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_word_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              irq_o
);

  localparam int P_W = CNT_W - SUB_W;   // stored count width
  localparam int L_W = LIM_W - SUB_W;   // stored limit width
  localparam int HI  = DATA_W - SUB_W;  // stored bit where the upper word starts

  logic           user_q, enter_user, enter_ctr;
  acc_t           acc;
  slot_e          slot;
  logic           rd_en, tick_g;
  logic [P_W-1:0] cnt;
  logic           match, wrap;
  logic [L_W-1:0] lim;
  logic           run;

  dmt_mode_track u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_user_i),
    .user_o       (user_q),
    .enter_user_o (enter_user),
    .enter_ctr_o  (enter_ctr)
  );

  dmt_decode u_dec (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_word_i  (req_word_i),
    .user_i      (user_q),
    .tick_i      (tick_i),
    .acc_o       (acc),
    .slot_o      (slot),
    .rd_o        (rd_en),
    .tick_o      (tick_g)
  );

  dmt_count_core #(
    .DATA_W (DATA_W), .SUB_W (SUB_W), .P_W (P_W), .L_W (L_W), .HI (HI)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_g),
    .user_i  (user_q),
    .run_i   (run),
    .lim_i   (lim),
    .clr_i   (acc.wr_limit_rst),
    .ld_hi_i (acc.ld_hi),
    .ld_lo_i (acc.ld_lo),
    .trunc_i (enter_ctr),
    .wdata_i (req_wdata_i),
    .cnt_o   (cnt),
    .match_o (match),
    .wrap_o  (wrap)
  );

  dmt_ctrl #(
    .DATA_W (DATA_W), .SUB_W (SUB_W), .P_W (P_W), .L_W (L_W), .HI (HI)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_i        (acc),
    .rd_i         (rd_en),
    .slot_i       (slot),
    .user_i       (user_q),
    .enter_user_i (enter_user),
    .enter_ctr_i  (enter_ctr),
    .match_i      (match),
    .wrap_i       (wrap),
    .cnt_i        (cnt),
    .lim_wd_i     (req_wdata_i[LIM_W-1:SUB_W]),
    .run_wd_i     (req_wdata_i[0]),
    .lim_o        (lim),
    .run_o        (run),
    .irq_o        (irq_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o)
  );

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R12

endmodule

// File: tb/dual_mode_timer_tb_top.sv
`timescale 1ns/1ps
module dual_mode_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        mode_in = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_word = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        irq;

  always #2 clk = ~clk; // 250 MHz

  dual_mode_timer dut_i (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .mode_user_i (mode_in),
    .req_valid_i (req_valid), .req_write_i (req_write), .req_word_i (req_word),
    .req_wdata_i (req_wdata), .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
    .irq_o (irq)
  );

  int    total = 0;
  int    bad = 0;
  string tag = "R1";

  // ---------------- behavioural reference model ----------------
  localparam logic [53:0] CMAX = '1;
  logic [53:0] m_cnt;
  logic [21:0] m_lim;
  logic        m_reached, m_irq, m_run, m_user, m_rv;
  logic [31:0] m_rd;
  logic        p_wr, p_rd;
  int          nstep;

  function automatic logic [31:0] model_read(input logic [1:0] w);
    logic [31:0] v;
    v = 32'h0;
    case (w)
      2'd0: v = m_user ? {m_reached, m_cnt[53:23]} : {1'b0, m_lim, 9'h0};
      2'd1: v = m_user ? {m_cnt[22:0], 9'h0} : {m_reached, m_cnt[21:0], 9'h0};
      2'd2: v = 32'h0;
      2'd3: v = {31'h0, m_run};
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_lim = '0; m_reached = 0; m_irq = 0;
      m_run = 1; m_user = 0; m_rv = 0; m_rd = '0;
    end else begin
      p_wr = req_valid && req_write;
      p_rd = req_valid && !req_write;
      m_rv = p_rd;
      if (p_rd) m_rd = model_read(req_word);
      if (p_rd && req_word == 2'd0 && !m_user) begin
        m_reached = 0; m_irq = 0;
      end
      if (tick && !p_wr) begin
        if (m_user) begin
          if (m_run) begin
            if (m_cnt == CMAX) begin m_cnt = '0; m_reached = 1; end
            else m_cnt = m_cnt + 54'd1;
          end
        end else begin
          nstep = int'(m_cnt[21:0]) + 1;
          if (m_lim != 0 && nstep >= int'(m_lim)) begin
            m_cnt = '0; m_reached = 1; m_irq = 1;
          end else begin
            m_cnt = 54'(nstep % (1 << 22));
          end
        end
      end
      if (p_wr) begin
        case (req_word)
          2'd0: if (m_user) begin m_cnt[53:23] = req_wdata[30:0]; m_reached = 0; end
                else begin m_lim = req_wdata[30:9]; m_cnt = '0; m_irq = 0; end
          2'd1: if (m_user) begin m_cnt[22:0] = req_wdata[31:9]; m_reached = 0; end
          2'd2: m_lim = req_wdata[30:9];
          2'd3: m_run = req_wdata[0];
          default: ;
        endcase
      end
      if (mode_in != m_user) begin
        if (mode_in) begin m_irq = 0; m_lim = '1; end
        else begin m_run = 1; m_cnt[53:22] = '0; end
        m_user = mode_in;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, m_irq);
      end
      total++;
      if (rsp_valid !== m_rv || (m_rv && rsp_data !== m_rd)) begin
        bad++;
        $display("FAIL %s (R12 response) actual=%0b/%h expected=%0b/%h",
                 tag, rsp_valid, rsp_data, m_rv, m_rd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic do_rd(input logic [1:0] w, input logic [31:0] exp, input string t);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = w; tick = 0;
    @(negedge clk);
    req_valid = 0;
    total++;
    if (rsp_valid !== 1'b1 || rsp_data !== exp) begin
      bad++;
      $display("FAIL %s read word %0d actual=%h expected=%h", t, w, rsp_data, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] w, input logic [31:0] d, input logic with_tick);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = w; req_wdata = d; tick = with_tick;
    @(negedge clk);
    req_valid = 0; req_write = 0; tick = 0;
  endtask

  task automatic do_tick(input int n);
    repeat (n) begin
      @(negedge clk);
      tick = 1;
    end
    @(negedge clk);
    tick = 0;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    mode_in = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string t);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;

    tag = "R1";
    chk_irq(1'b0, "R1");
    do_rd(2'd3, 32'h1, "R1");
    do_rd(2'd0, 32'h0, "R1");
    do_rd(2'd1, 32'h0, "R1");

    tag = "R2";
    do_tick(3);
    do_rd(2'd1, 32'h0000_0600, "R2");
    do_wr(2'd0, 32'h0000_0A00, 1'b0);
    do_tick(4);
    chk_irq(1'b0, "R2");
    do_tick(1);
    chk_irq(1'b1, "R2");
    do_rd(2'd1, 32'h8000_0000, "R2");

    tag = "R4";
    do_rd(2'd0, 32'h0000_0A00, "R4");
    chk_irq(1'b0, "R4");
    do_rd(2'd1, 32'h0, "R4");
    do_wr(2'd1, 32'h0001_2345, 1'b0);
    do_rd(2'd1, 32'h0, "R4");

    tag = "R5";
    do_tick(2);
    do_wr(2'd2, 32'h0000_1000, 1'b0);
    do_rd(2'd1, 32'h0000_0400, "R5");
    do_rd(2'd2, 32'h0, "R5");

    tag = "R3";
    do_wr(2'd0, 32'h0, 1'b0);
    do_tick(20);
    chk_irq(1'b0, "R3");
    do_rd(2'd1, 32'h0000_2800, "R3");

    tag = "R9";
    do_wr(2'd3, 32'h0, 1'b0);
    do_tick(1);
    do_rd(2'd1, 32'h0000_2A00, "R2");
    do_rd(2'd3, 32'h0, "R9");

    tag = "R12";
    do_wr(2'd0, 32'h0000_0400, 1'b0);
    do_tick(1);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = 2'd0; tick = 1;
    @(negedge clk);
    req_valid = 0; tick = 0;
    total++;
    if (rsp_data !== 32'h0000_0400) begin
      bad++;
      $display("FAIL R12 read data actual=%h expected=%h", rsp_data, 32'h0000_0400);
    end
    chk_irq(1'b1, "R12");

    tag = "R10";
    set_mode(1'b1);
    chk_irq(1'b0, "R10");

    tag = "R8";
    do_tick(5);
    do_rd(2'd1, 32'h0, "R8");
    do_rd(2'd0, 32'h8000_0000, "R6");

    tag = "R7";
    do_wr(2'd3, 32'h1, 1'b0);
    do_wr(2'd0, 32'h7FFF_FFFF, 1'b0);
    do_wr(2'd1, 32'hFFFF_FC00, 1'b0);
    do_rd(2'd0, 32'h7FFF_FFFF, "R7");
    do_tick(1);
    do_rd(2'd1, 32'hFFFF_FE00, "R6");
    do_tick(1);
    do_rd(2'd0, 32'h8000_0000, "R8");
    do_rd(2'd1, 32'h0, "R8");
    chk_irq(1'b0, "R8");
    do_wr(2'd1, 32'h0000_0400, 1'b0);
    do_rd(2'd0, 32'h0, "R7");
    do_tick(1);
    do_rd(2'd1, 32'h0000_0600, "R7");

    tag = "R12";
    do_wr(2'd3, 32'h1, 1'b1);
    do_rd(2'd1, 32'h0000_0600, "R12");

    tag = "R11";
    do_wr(2'd0, 32'h0000_0001, 1'b0);
    do_wr(2'd1, 32'h0000_0200, 1'b0);
    do_wr(2'd3, 32'h0, 1'b0);
    set_mode(1'b0);
    do_rd(2'd3, 32'h1, "R11");
    do_rd(2'd1, 32'h0000_0200, "R11");
    do_rd(2'd0, 32'h7FFF_FE00, "R10");
    do_tick(1);
    do_rd(2'd1, 32'h0000_0400, "R11");

    // mixed traffic checked against the model every cycle
    tag = "R2-mix";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick      = ($urandom % 3) == 0;
      req_valid = ($urandom % 3) == 0;
      req_write = $urandom % 2;
      req_word  = 2'($urandom % 4);
      req_wdata = $urandom;
      if (($urandom % 3) == 0) req_wdata[31:12] = '0;
      if (($urandom % 97) == 0) mode_in = ~mode_in;
    end
    @(negedge clk);
    tick = 0; req_valid = 0; req_write = 0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule